// File: doc/BRIEF.md
# Soft-Start Sequencer with Enable Qualification

This block decides when a multiphase PWM regulator is allowed to run, and it generates the digital references used during start-up. Three conditions must hold together before the block leaves shutdown: the supply power-on flag is good, the enable comparator output is high, and the 5-bit voltage-select code is not the reserved all-ones "no load" code. Once all three hold, a soft-start begins at once. The soft-start is timed by an 11-bit counter that advances on phase-clock pulses, so a full soft-start takes 2048 phase periods.

During soft-start, a ramp reference climbs linearly from zero to 140% of the DAC target taken from the voltage-select code. At the same time, an offset-current code falls linearly from full scale, which stands for 160 µA, down to zero. The reference given to the regulation loop is the lower of the DAC target and the ramp. A first-pulse flag tells the modulator when the ramp has climbed past a programmable offset threshold. A done flag marks the end of the count. If any qualifying condition is lost, the block returns to shutdown on the next clock. Shutdown clears all of its state, and a later restart begins again from zero.

Top module: `softstart_seq`

## Requirements
- R1: `run_o` is high in a cycle only if `por_ok`, `en_ok` were high and `vid` was not 5'b11111 at the preceding rising clock edge. Once all three hold at an edge, `run_o` is high right after that edge.
- R2: After reset, or after any clock edge at which the start conditions of R1 fail, `run_o`, `done_o`, `first_pulse_o`, `ramp_o`, `ofs_o` and `ref_o` are all zero, and the step counter is cleared.
- R3: While running, the step counter (0..2047) advances by one at each clock edge where `ph_tick` is high. It is held at edges where `ph_tick` is low, and it holds at 2047 once reached.
- R4: While running, `ramp_o` = (dac × 358 × p) >> 19. Here p is the counter value, except that p = 2048 at terminal count, and 358/256 approximates 1.4. `ramp_o` starts at 0 and never falls while the run and `vid` are unchanged.
- R5: While running, `ofs_o` = floor(255 × (2047 − count) / 2047). This gives 255 at the start of soft-start and exactly 0 at terminal count.
- R6: `ref_o` equals the smaller of the DAC target and `ramp_o` in every running cycle.
- R7: `first_pulse_o` is high exactly when the block is running and `ramp_o` > `ofs_thr`.
- R8: At terminal count `done_o` is high and stays high while running. In that state `ref_o` equals the DAC target and `ofs_o` is 0.
- R9: The DAC target for code v in 0..30 is 1550 − 25·v, in DAC LSBs.
- R10: A restart after shutdown begins again from count 0, with `ramp_o` = 0 and `ofs_o` = 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph_tick | input | 1 | One-cycle phase-clock pulse |
| por_ok | input | 1 | Supply power-on-reset good |
| en_ok | input | 1 | Enable comparator output |
| vid | input | 5 | Voltage-select code; all ones means no load |
| ofs_thr | input | 12 | Offset threshold for the first-pulse flag |
| run_o | output | 1 | Regulator allowed to run |
| done_o | output | 1 | Soft-start complete |
| first_pulse_o | output | 1 | Ramp has passed the offset threshold |
| ramp_o | output | 12 | Ramp reference, rising to 1.4 × target |
| ofs_o | output | 8 | Offset-current code, falling to zero |
| ref_o | output | 11 | Effective reference, min(target, ramp) |

## Verification
The step counter cannot be seen directly. A wrong count shows up in `ramp_o` and `ofs_o` in the same cycle it goes wrong, because both are combinational functions of the counter. A miscounted phase pulse therefore shows as a wrong ramp value right after that edge. A run flag stuck in the wrong state shows within one cycle of a qualifier change, as non-zero outputs in shutdown or as zero outputs while running. A counter that fails to clear shows at the first cycle of a restart, as `ofs_o` below full scale. A counter that fails to hold shows after terminal count, as `done_o` dropping or the offset code leaving zero.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

   // round(1.4 * 2^frac) as an unsigned fixed-point gain
   function automatic int unsigned gain_q(input int unsigned frac);
      return (14 * (32'd1 << frac) + 5) / 10;
   endfunction

   // number of bits needed to hold value v
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((64'd1 << n) <= v) n++;
      return n;
   endfunction

endpackage

// File: rtl/ss_gate.sv
module ss_gate #(
   parameter int VID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             en_ok,
   input  logic [VID_W-1:0] vid,
   output logic             qual,
   output logic             run
);

   if (VID_W < 2) begin : g_bad_vid
      $error("ss_gate: VID_W must be at least 2");
   end

   logic no_load;
   assign no_load = &vid;
   assign qual    = por_ok & en_ok & ~no_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= qual;
   end

   // R1: a run may only begin after all three start conditions held
   assert_start_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(por_ok && en_ok && !(&vid)));

   // R2: losing any condition ends the run at the next edge
   assert_stop_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_ok || !en_ok || (&vid)) |=> !run);

endmodule

// File: rtl/ss_counter.sv
module ss_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual,
   input  logic             run,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             at_end
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 2 || CNT_W > 20) begin : g_bad_cnt
      $error("ss_counter: CNT_W out of range");
   end

   assign at_end = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!qual)                  cnt <= '0;
      else if (run && step && !at_end) cnt <= cnt + 1'b1;
   end

   // R3: no phase pulse, no advance
   assert_cnt_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && !step) |=> $stable(cnt));

   // R3: the count never moves by more than one per edge
   assert_cnt_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && run) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

   // R8: terminal count is sticky while qualified
   assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && at_end) |=> at_end);

   // R2: shutdown clears the count
   assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> (cnt == '0));

endmodule

// File: rtl/ss_vid_lut.sv
module ss_vid_lut #(
   parameter int VID_W     = 5,
   parameter int DAC_W     = 11,
   parameter int DAC_TOP   = 1550,
   parameter int DAC_STEP  = 25,
   parameter bit LUT_TABLE = 1'b1
) (
   input  logic [VID_W-1:0] vid,
   output logic [DAC_W-1:0] dac
);

   localparam int NCODE = 1 << VID_W;

   if (DAC_TOP >= (1 << DAC_W)) begin : g_bad_top
      $error("ss_vid_lut: DAC_TOP does not fit DAC_W");
   end
   if (DAC_TOP < (NCODE - 2) * DAC_STEP) begin : g_bad_step
      $error("ss_vid_lut: lowest code would go negative");
   end

   if (LUT_TABLE) begin : g_table
      logic [DAC_W-1:0] tbl [NCODE];
      for (genvar i = 0; i < NCODE; i++) begin : g_ent
         if (i == NCODE - 1) begin : g_noload
            assign tbl[i] = '0;
         end else begin : g_code
            assign tbl[i] = DAC_W'(DAC_TOP - i * DAC_STEP);
         end
      end
      assign dac = tbl[vid];
   end else begin : g_arith
      always_comb begin
         if (&vid) dac = '0;
         else      dac = DAC_W'(DAC_TOP - int'(vid) * DAC_STEP);
      end
   end

endmodule

// File: rtl/ss_ramp_math.sv
module ss_ramp_math #(
   parameter int CNT_W     = 11,
   parameter int DAC_W     = 11,
   parameter int OFS_W     = 8,
   parameter int OFS_FULL  = 255,
   parameter int GAIN_FRAC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic             at_end,
   input  logic [DAC_W-1:0] dac,
   input  logic [DAC_W:0]   thr,
   output logic [DAC_W:0]   ramp,
   output logic [OFS_W-1:0] ofs,
   output logic [DAC_W-1:0] eff,
   output logic             fp
);
   import softstart_pkg::*;

   localparam int unsigned GAIN   = gain_q(GAIN_FRAC);
   localparam int          GAIN_W = bits_for(GAIN);
   localparam int          POS_W  = CNT_W + 1;
   localparam int          PROD_W = DAC_W + GAIN_W + POS_W;
   localparam int          SHIFT  = GAIN_FRAC + CNT_W;
   localparam int          CMAX   = (1 << CNT_W) - 1;
   localparam int          ONUM_W = OFS_W + CNT_W;
   localparam int          RAMP_W = DAC_W + 1;

   if (OFS_FULL >= (1 << OFS_W)) begin : g_bad_ofs
      $error("ss_ramp_math: OFS_FULL does not fit OFS_W");
   end
   if (GAIN_FRAC < 4 || GAIN_FRAC > 12) begin : g_bad_frac
      $error("ss_ramp_math: GAIN_FRAC out of range");
   end

   logic [POS_W-1:0]  pos;
   logic [PROD_W-1:0] prod;
   logic [ONUM_W-1:0] onum;
   logic [RAMP_W-1:0] ramp_raw;
   logic [OFS_W-1:0]  ofs_raw;

   // the last step jumps to the full 2^CNT_W so the ramp lands on 1.4x target
   assign pos      = at_end ? POS_W'(1 << CNT_W) : {1'b0, cnt};
   assign prod     = PROD_W'(dac) * PROD_W'(GAIN) * PROD_W'(pos);
   assign ramp_raw = RAMP_W'(prod >> SHIFT);

   assign onum     = ONUM_W'(OFS_FULL) * ONUM_W'(CNT_W'(CMAX) - cnt);
   assign ofs_raw  = OFS_W'(onum / ONUM_W'(CMAX));

   assign ramp = run ? ramp_raw : '0;
   assign ofs  = run ? ofs_raw  : '0;
   assign eff  = !run ? '0 :
                 (ramp_raw < {1'b0, dac}) ? DAC_W'(ramp_raw) : dac;
   assign fp   = run && (ramp_raw > thr);

   // R6: the loop reference never exceeds the target
   assert_ref_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, eff} <= {1'b0, dac});

   // R8: at the end of soft-start the offset is gone and the clamp is on target
   assert_end_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_end) |-> (ofs == '0) && (eff == dac));

   // R2: shutdown outputs are all zero
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (ramp == '0) && (ofs == '0) && (eff == '0) && !fp);

   // R4: the ramp never falls during an unbroken run on one code
   assert_ramp_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $stable(dac)) |-> (ramp >= $past(ramp)));

   // R5: the offset code never rises during an unbroken run
   assert_ofs_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (ofs <= $past(ofs)));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
   parameter int CNT_W     = 11,
   parameter int VID_W     = 5,
   parameter int DAC_W     = 11,
   parameter int DAC_TOP   = 1550,
   parameter int DAC_STEP  = 25,
   parameter int OFS_W     = 8,
   parameter int OFS_FULL  = 255,
   parameter int GAIN_FRAC = 8,
   parameter bit LUT_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph_tick,
   input  logic             por_ok,
   input  logic             en_ok,
   input  logic [VID_W-1:0] vid,
   input  logic [DAC_W:0]   ofs_thr,
   output logic             run_o,
   output logic             done_o,
   output logic             first_pulse_o,
   output logic [DAC_W:0]   ramp_o,
   output logic [OFS_W-1:0] ofs_o,
   output logic [DAC_W-1:0] ref_o
);

   logic             qual;
   logic             run;
   logic [CNT_W-1:0] cnt;
   logic             at_end;
   logic [DAC_W-1:0] dac;

   ss_gate #(.VID_W(VID_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_ok(en_ok),
      .vid(vid), .qual(qual), .run(run)
   );

   ss_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .qual(qual), .run(run),
      .step(ph_tick), .cnt(cnt), .at_end(at_end)
   );

   ss_vid_lut #(
      .VID_W(VID_W), .DAC_W(DAC_W), .DAC_TOP(DAC_TOP),
      .DAC_STEP(DAC_STEP), .LUT_TABLE(LUT_TABLE)
   ) u_lut (
      .vid(vid), .dac(dac)
   );

   ss_ramp_math #(
      .CNT_W(CNT_W), .DAC_W(DAC_W), .OFS_W(OFS_W),
      .OFS_FULL(OFS_FULL), .GAIN_FRAC(GAIN_FRAC)
   ) u_math (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .at_end(at_end),
      .dac(dac), .thr(ofs_thr), .ramp(ramp_o), .ofs(ofs_o),
      .eff(ref_o), .fp(first_pulse_o)
   );

   assign run_o  = run;
   assign done_o = run & at_end;

   // R8: done never drops while the block stays qualified
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && qual) |=> done_o);

   // R10: the first running cycle always starts from the bottom of the ramp
   assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> (ramp_o == '0) && (ofs_o == OFS_W'(OFS_FULL)));

endmodule

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ph_tick = 1'b0, por_ok = 1'b0, en_ok = 1'b0;
   logic [4:0]  vid = 5'd0;
   logic [11:0] ofs_thr = 12'd0;
   logic        run_o, done_o, first_pulse_o;
   logic [11:0] ramp_o;
   logic [7:0]  ofs_o;
   logic [10:0] ref_o;

   int errors = 0, checks = 0;
   bit fin = 1'b0;

   // model state derived from the requirements
   bit m_run = 1'b0;
   int m_cnt = 0;
   int prev_ramp = -1;

   always #5 clk = ~clk;

   softstart_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ph_tick(ph_tick), .por_ok(por_ok),
      .en_ok(en_ok), .vid(vid), .ofs_thr(ofs_thr), .run_o(run_o),
      .done_o(done_o), .first_pulse_o(first_pulse_o), .ramp_o(ramp_o),
      .ofs_o(ofs_o), .ref_o(ref_o)
   );

   function automatic int exp_dac(input int v);
      return (v == 31) ? 0 : 1550 - 25 * v;   // R9
   endfunction

   function automatic int exp_ramp(input int v, input int c);
      longint p;
      p = (c == 2047) ? 2048 : c;
      return int'((longint'(exp_dac(v)) * 358 * p) >>> 19);  // R4
   endfunction

   function automatic int exp_ofs(input int c);
      return (255 * (2047 - c)) / 2047;   // R5
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      int er, eo, ed, ee;
      if (m_run) begin
         er = exp_ramp(int'(vid), m_cnt);
         eo = exp_ofs(m_cnt);
         ed = exp_dac(int'(vid));
         ee = (er < ed) ? er : ed;
      end else begin
         er = 0; eo = 0; ee = 0;
      end
      chk("R1 run_o", int'(run_o), int'(m_run));
      chk(m_run ? "R4 ramp_o" : "R2 ramp_o idle", int'(ramp_o), er);
      chk(m_run ? "R5 ofs_o" : "R2 ofs_o idle", int'(ofs_o), eo);
      chk("R6 ref_o", int'(ref_o), ee);
      chk("R8 done_o", int'(done_o), int'(m_run && m_cnt == 2047));
      chk("R7 first_pulse_o", int'(first_pulse_o), int'(m_run && er > int'(ofs_thr)));
   endtask

   task automatic tick(input bit p, input bit pr, input bit e,
                       input int v, input int thr);
      bit q;
      @(negedge clk);
      ph_tick = p; por_ok = pr; en_ok = e; vid = 5'(v); ofs_thr = 12'(thr);
      @(posedge clk);
      q = pr && e && (v != 31);
      if (!q)                               m_cnt = 0;
      else if (m_run && p && m_cnt != 2047) m_cnt = m_cnt + 1;
      m_run = q;
      #2;
      check_all();
   endtask

   initial begin
      int rv, rthr;
      bit rp, rpor, ren;
      void'($urandom(32'd20240517));
      repeat (3) @(posedge clk);
      #2;
      check_all();                      // R2 reset state
      @(negedge clk) rst_n = 1'b1;

      // R1: each missing condition keeps the block in shutdown
      repeat (4) tick(1, 0, 1, 5, 0);
      repeat (4) tick(1, 1, 0, 5, 0);
      repeat (4) tick(1, 1, 1, 31, 0);
      chk("R1 no-load code blocks start", int'(run_o), 0);

      // R10/R4/R5/R8: full ramp on code 3, pulse every cycle
      tick(0, 1, 1, 3, 300);
      chk("R10 start ramp zero", int'(ramp_o), 0);
      chk("R10 start ofs full", int'(ofs_o), 255);
      prev_ramp = -1;
      for (int i = 0; i < 2060; i++) begin
         tick(1, 1, 1, 3, 300);
         if (int'(ramp_o) < prev_ramp) chk("R4 monotonic", int'(ramp_o), prev_ramp);
         prev_ramp = int'(ramp_o);
      end
      chk("R8 done at end", int'(done_o), 1);
      chk("R8 ref on target", int'(ref_o), exp_dac(3));
      chk("R8 ofs zero", int'(ofs_o), 0);
      chk("R4 ramp at 1.4x", int'(ramp_o), (1475 * 358) >> 8);

      // R8: hold at terminal count, pulses ignored
      repeat (10) tick(1, 1, 1, 3, 300);
      chk("R3 hold at terminal", int'(done_o), 1);

      // R3: no pulses -> no motion; then R2 drop enable mid-ramp, R10 restart
      tick(0, 0, 1, 0, 50);
      repeat (40) tick(1, 1, 1, 0, 50);
      repeat (20) tick(0, 1, 1, 0, 50);
      chk("R3 held without pulse", int'(ofs_o), exp_ofs(39));
      tick(1, 1, 0, 0, 50);
      chk("R2 shutdown on enable loss", int'(run_o), 0);
      tick(1, 1, 1, 0, 50);
      chk("R10 restart ofs full", int'(ofs_o), 255);

      // R2: no-load code mid-run
      repeat (30) tick(1, 1, 1, 30, 50);
      tick(1, 1, 1, 31, 50);
      chk("R2 shutdown on code 31", int'(ramp_o), 0);

      // R9: target table via terminal reference for several codes
      for (int v = 0; v < 31; v += 6) begin
         tick(0, 0, 0, v, 0);
         repeat (2050) tick(1, 1, 1, v, 0);
         chk("R9 target", int'(ref_o), 1550 - 25 * v);
      end

      // random phase: sparse pulses, rare drops and code changes
      rv = 7; rthr = 200;
      for (int i = 0; i < 40000; i++) begin
         rp   = ($urandom_range(0, 3) != 0);
         rpor = ($urandom_range(0, 999) != 0);
         ren  = ($urandom_range(0, 599) != 0);
         if ($urandom_range(0, 799) == 0) rv = $urandom_range(0, 31);
         if ($urandom_range(0, 99) == 0)  rthr = $urandom_range(0, 2200);
         tick(rp, rpor, ren, rv, rthr);
      end

      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule